// File: doc/BRIEF.md
# Interrupt and GPIO Pin Controller

This block merges three interrupt sources into one request and presents it on two output pads. Two sources are per-slot sample-done events, caught in sticky status bits and gated by per-slot mask bits. The third is a level condition that holds while the FIFO word count is above a programmed threshold. Software clears a sticky bit with a write-one-to-clear pulse. The FIFO condition clears itself as soon as the count drops to the threshold or below.

Each pad has an active-level bit and a drive-mode bit. In push-pull mode the pad is always driven. In open-drain style mode it is driven only while its request is asserted, so several devices can share one wire. Pad 0 also has an enable bit, and it always carries the interrupt. Pad 1 has a 5-bit function code. Code 1 routes the interrupt to pad 1. Code 2 routes a window that opens on the slot-sequence start strobe and closes on the end strobe. Every other code leaves pad 1 undriven.

Each pad output is a data bit plus an output-enable for a tri-state buffer. Both are registered. Register fields arrive as plain input ports.

Top module: `irq_pin_ctrl`

## Requirements
- R1: When a slot's mask bit is 1, an event on that slot does not assert the interrupt. Mask bit 0 lets the event through.
- R2: A sample-done pulse on slot i sets sticky bit i. The bit stays set until a pulse on clear bit i. If set and clear arrive in the same cycle, the set wins.
- R3: The FIFO condition asserts the interrupt while fifo_count > fifo_thresh (strictly greater). It deasserts without any clear once fifo_count <= fifo_thresh.
- R4: A pad's asserted level is 1 when its polarity bit is 0, and 0 when its polarity bit is 1. The deasserted level is the opposite.
- R5: With drive bit 0 the pad's output-enable is 1 at all times. With drive bit 1 it is 1 only while the pad's request is asserted.
- R6: With p0_en = 0, p0_oe is 0 whatever the interrupt does, and the sticky status still captures events. Setting p0_en = 1 then shows the captured interrupt.
- R7: With p1_alt = 1, pad 1 carries the interrupt.
- R8: With p1_alt = 2, pad 1 carries a window. seq_start opens the window and seq_end closes it. If both strobes arrive in the same cycle, start wins. The pad follows the strobe two clock edges later.
- R9: Any p1_alt value other than 1 or 2 (including 0) holds p1_oe at 0.
- R10: Pad outputs are registered. A change in the interrupt appears one clock edge later, and the pads reset to data 0, output-enable 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| slot_done | input | NSLOT | Per-slot sample-done pulses |
| slot_clr | input | NSLOT | Per-slot write-one-to-clear pulses for the sticky bits |
| slot_mask | input | NSLOT | Per-slot mask; 1 blocks the slot |
| seq_start | input | 1 | Start of the first slot of a sequence |
| seq_end | input | 1 | End of the last slot of a sequence |
| fifo_count | input | CNT_W | Words currently in the FIFO |
| fifo_thresh | input | THR_W | FIFO level threshold |
| p0_en | input | 1 | Pad 0 enable |
| p0_drv | input | 1 | Pad 0 drive mode (1 = driven only when asserted) |
| p0_pol | input | 1 | Pad 0 polarity (1 = active low) |
| p1_drv | input | 1 | Pad 1 drive mode |
| p1_pol | input | 1 | Pad 1 polarity |
| p1_alt | input | 5 | Pad 1 function code |
| p0_out | output | 1 | Pad 0 data |
| p0_oe | output | 1 | Pad 0 output-enable |
| p1_out | output | 1 | Pad 1 data |
| p1_oe | output | 1 | Pad 1 output-enable |

## Verification
The bench uses the defaults NSLOT = 2, CNT_W = 7 and THR_W = 6. Because the count is one bit wider than the threshold, the count can exceed the largest threshold (64 against 63), so the upper boundary of the strict comparison is within reach. Two slots are enough to show that a mask on one slot does not block the other, and that set and clear in the same cycle resolve per bit. All four polarity and drive-mode pairings are swept on a live interrupt, which covers both undriven states.

// File: rtl/irq_pin_pkg.sv
package irq_pin_pkg;
  localparam int ALT_W = 5;
  typedef enum logic [ALT_W-1:0] {
    ALT_IRQ    = 5'd1,
    ALT_WINDOW = 5'd2
  } p1_func_e;
endpackage

// File: rtl/irq_reset_sync.sv
module irq_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/irq_status.sv
module irq_status #(
  parameter int NSLOT = 2,
  parameter int CNT_W = 7,
  parameter int THR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] slot_done,
  input  logic [NSLOT-1:0] slot_clr,
  input  logic [NSLOT-1:0] slot_mask,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic [THR_W-1:0] fifo_thresh,
  output logic             irq
);
  logic [NSLOT-1:0] sticky_q, sticky_d, sticky_en;
  logic [CNT_W-1:0] thr_ext;
  logic             fifo_over;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    always_comb begin
      sticky_en[i] = slot_done[i] | slot_clr[i];
      sticky_d[i]  = slot_done[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            sticky_q[i] <= 1'b0;
      else if (sticky_en[i]) sticky_q[i] <= sticky_d[i];
    end

    assert_sticky_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      slot_done[i] |=> sticky_q[i]);
    assert_sticky_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sticky_q[i] && !slot_clr[i]) |=> sticky_q[i]);
  end

  always_comb begin
    thr_ext   = CNT_W'(fifo_thresh);
    fifo_over = fifo_count > thr_ext;
    irq       = fifo_over | (|(sticky_q & ~slot_mask));
  end

  assert_fifo_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count > CNT_W'(fifo_thresh)) |-> irq);
  assert_mask_block_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (&slot_mask && !(fifo_count > CNT_W'(fifo_thresh))) |-> !irq);
endmodule

// File: rtl/seq_window.sv
module seq_window (
  input  logic clk,
  input  logic rst_n,
  input  logic seq_start,
  input  logic seq_end,
  output logic win
);
  logic win_q, win_d, win_en;

  always_comb begin
    win_en = seq_start | seq_end;
    win_d  = seq_start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      win_q <= 1'b0;
    else if (win_en) win_q <= win_d;
  end

  assign win = win_q;

  assert_win_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> win_q);
  assert_win_close_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_end && !seq_start) |=> !win_q);
endmodule

// File: rtl/pin_driver.sv
module pin_driver (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic drv_od,
  input  logic pol,
  input  logic req,
  output logic pad_d,
  output logic pad_oe
);
  logic d_q, d_nxt, oe_q, oe_nxt;

  always_comb begin
    d_nxt  = req ^ pol;
    oe_nxt = en & (req | ~drv_od);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q  <= 1'b0;
      oe_q <= 1'b0;
    end else begin
      d_q  <= d_nxt;
      oe_q <= oe_nxt;
    end
  end

  assign pad_d  = d_q;
  assign pad_oe = oe_q;

  assert_disabled_float_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pad_oe);
  assert_pushpull_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !drv_od) |=> pad_oe);
  assert_od_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_od && !req) |=> !pad_oe);
endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl
  import irq_pin_pkg::*;
#(
  parameter int NSLOT = 2,
  parameter int CNT_W = 7,
  parameter int THR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] slot_done,
  input  logic [NSLOT-1:0] slot_clr,
  input  logic [NSLOT-1:0] slot_mask,
  input  logic             seq_start,
  input  logic             seq_end,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic [THR_W-1:0] fifo_thresh,
  input  logic             p0_en,
  input  logic             p0_drv,
  input  logic             p0_pol,
  input  logic             p1_drv,
  input  logic             p1_pol,
  input  logic [ALT_W-1:0] p1_alt,
  output logic             p0_out,
  output logic             p0_oe,
  output logic             p1_out,
  output logic             p1_oe
);
  logic rst_i_n, irq, win, p1_req, p1_en;

  irq_reset_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  irq_status #(.NSLOT(NSLOT), .CNT_W(CNT_W), .THR_W(THR_W)) u_status (
    .clk(clk), .rst_n(rst_i_n), .slot_done(slot_done), .slot_clr(slot_clr),
    .slot_mask(slot_mask), .fifo_count(fifo_count), .fifo_thresh(fifo_thresh),
    .irq(irq));

  seq_window u_win (
    .clk(clk), .rst_n(rst_i_n), .seq_start(seq_start), .seq_end(seq_end),
    .win(win));

  always_comb begin
    p1_req = 1'b0;
    p1_en  = 1'b0;
    if (p1_alt == ALT_IRQ) begin
      p1_req = irq;
      p1_en  = 1'b1;
    end else if (p1_alt == ALT_WINDOW) begin
      p1_req = win;
      p1_en  = 1'b1;
    end
  end

  pin_driver u_pad0 (
    .clk(clk), .rst_n(rst_i_n), .en(p0_en), .drv_od(p0_drv), .pol(p0_pol),
    .req(irq), .pad_d(p0_out), .pad_oe(p0_oe));

  pin_driver u_pad1 (
    .clk(clk), .rst_n(rst_i_n), .en(p1_en), .drv_od(p1_drv), .pol(p1_pol),
    .req(p1_req), .pad_d(p1_out), .pad_oe(p1_oe));

  assert_alt_unused_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (p1_alt != ALT_IRQ && p1_alt != ALT_WINDOW) |=> !p1_oe);
  assert_pad_reg_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    (p0_en && !p0_drv && $stable(irq) && $stable(p0_pol)) |=> $stable(p0_out));
endmodule

// File: tb/test_irq_pin_ctrl.sv
module test_irq_pin_ctrl;
  localparam int NSLOT = 2;
  localparam int CNT_W = 7;
  localparam int THR_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSLOT-1:0] slot_done = '0, slot_clr = '0, slot_mask = '1;
  logic seq_start = 1'b0, seq_end = 1'b0;
  logic [CNT_W-1:0] fifo_count = '0;
  logic [THR_W-1:0] fifo_thresh = '0;
  logic p0_en = 1'b0, p0_drv = 1'b0, p0_pol = 1'b0;
  logic p1_drv = 1'b0, p1_pol = 1'b0;
  logic [4:0] p1_alt = '0;
  logic p0_out, p0_oe, p1_out, p1_oe;

  int tests = 0, fails = 0;
  bit cmp_on = 1'b0;
  bit done_flag = 1'b0;
  string cur_req = "R10";

  // reference model state
  bit [NSLOT-1:0] m_st;
  bit m_win, m_d0, m_oe0, m_d1, m_oe1;

  always #2 clk = ~clk;

  irq_pin_ctrl #(.NSLOT(NSLOT), .CNT_W(CNT_W), .THR_W(THR_W)) i_irq_pin_ctrl (
    .clk(clk), .rst_n(rst_n), .slot_done(slot_done), .slot_clr(slot_clr),
    .slot_mask(slot_mask), .seq_start(seq_start), .seq_end(seq_end),
    .fifo_count(fifo_count), .fifo_thresh(fifo_thresh), .p0_en(p0_en),
    .p0_drv(p0_drv), .p0_pol(p0_pol), .p1_drv(p1_drv), .p1_pol(p1_pol),
    .p1_alt(p1_alt), .p0_out(p0_out), .p0_oe(p0_oe), .p1_out(p1_out),
    .p1_oe(p1_oe));

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = '0; m_win = 0; m_d0 = 0; m_oe0 = 0; m_d1 = 0; m_oe1 = 0;
    end else begin
      bit irq_m, r1, e1;
      irq_m = (int'(fifo_count) > int'(fifo_thresh));
      for (int i = 0; i < NSLOT; i++) if (m_st[i] && !slot_mask[i]) irq_m = 1;
      r1 = 0; e1 = 0;
      if (p1_alt == 5'd1) begin r1 = irq_m; e1 = 1; end
      else if (p1_alt == 5'd2) begin r1 = m_win; e1 = 1; end
      m_d0  = irq_m ? !p0_pol : p0_pol;
      m_oe0 = p0_en && (irq_m || !p0_drv);
      m_d1  = r1 ? !p1_pol : p1_pol;
      m_oe1 = e1 && (r1 || !p1_drv);
      for (int i = 0; i < NSLOT; i++) begin
        if (slot_done[i]) m_st[i] = 1;
        else if (slot_clr[i]) m_st[i] = 0;
      end
      if (seq_start) m_win = 1;
      else if (seq_end) m_win = 0;
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    chk({cur_req, " pad0 oe"}, p0_oe, m_oe0);
    chk({cur_req, " pad1 oe"}, p1_oe, m_oe1);
    if (m_oe0) chk({cur_req, " pad0 data"}, p0_out, m_d0);
    if (m_oe1) chk({cur_req, " pad1 data"}, p1_out, m_d1);
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1;
    step(4);
    chk("R10 reset oe0", p0_oe, 1'b0);
    chk("R10 reset oe1", p1_oe, 1'b0);
    chk("R10 reset d0", p0_out, 1'b0);
    cmp_on = 1;

    // R1: masked slot event
    cur_req = "R1";
    p0_en = 1; p0_drv = 1;
    slot_done = 2'b01; step(1); slot_done = 0; step(3);
    chk("R1 masked event", p0_oe, 1'b0);
    slot_clr = 2'b11; step(1); slot_clr = 0; step(2);

    // R2: sticky set, hold, clear, set-wins
    cur_req = "R2";
    slot_mask = 2'b00;
    slot_done = 2'b10; step(1); slot_done = 0; step(2);
    chk("R2 sticky set oe", p0_oe, 1'b1);
    chk("R2 sticky set data", p0_out, 1'b1);
    step(5);
    chk("R2 sticky hold", p0_oe, 1'b1);
    slot_clr = 2'b10; step(1); slot_clr = 0; step(2);
    chk("R2 cleared", p0_oe, 1'b0);
    slot_done = 2'b01; slot_clr = 2'b01; step(1); slot_done = 0; slot_clr = 0; step(2);
    chk("R2 set wins", p0_oe, 1'b1);
    slot_clr = 2'b11; step(1); slot_clr = 0; step(2);
    slot_mask = 2'b10;
    slot_done = 2'b10; step(1); slot_done = 0; step(2);
    chk("R1 other slot masked", p0_oe, 1'b0);
    slot_clr = 2'b11; step(1); slot_clr = 0; slot_mask = 2'b11; step(2);

    // R3: FIFO level
    cur_req = "R3";
    fifo_thresh = 6'd5; fifo_count = 7'd5; step(2);
    chk("R3 equal not over", p0_oe, 1'b0);
    fifo_count = 7'd6; step(2);
    chk("R3 above", p0_oe, 1'b1);
    fifo_count = 7'd3; step(2);
    chk("R3 self clear", p0_oe, 1'b0);
    fifo_thresh = 6'd63; fifo_count = 7'd63; step(2);
    chk("R3 max equal", p0_oe, 1'b0);
    fifo_count = 7'd64; step(2);
    chk("R3 max above", p0_oe, 1'b1);
    fifo_count = 7'd0; step(2);

    // R4 / R5: polarity x drive sweep
    for (int k = 0; k < 4; k++) begin
      cur_req = "R4R5";
      p0_pol = k[0]; p0_drv = k[1];
      fifo_count = 7'd0; step(2);
      chk("R5 idle oe", p0_oe, !p0_drv);
      if (!p0_drv) chk("R4 idle level", p0_out, p0_pol);
      fifo_count = 7'd100; step(2);
      chk("R5 active oe", p0_oe, 1'b1);
      chk("R4 active level", p0_out, !p0_pol);
    end
    fifo_count = 0; p0_pol = 0; p0_drv = 0; step(2);

    // R6: disabled pad, status still updates
    cur_req = "R6";
    p0_en = 0; fifo_count = 7'd100; step(2);
    chk("R6 disabled with irq", p0_oe, 1'b0);
    fifo_count = 0; slot_mask = 2'b00;
    slot_done = 2'b01; step(1); slot_done = 0; step(2);
    chk("R6 disabled event", p0_oe, 1'b0);
    p0_en = 1; step(2);
    chk("R6 captured after enable", p0_oe, 1'b1);
    slot_clr = 2'b11; step(1); slot_clr = 0; slot_mask = 2'b11; step(2);

    // R7: interrupt on pad 1
    cur_req = "R7";
    p1_alt = 5'd1; p1_pol = 1; p1_drv = 0; step(2);
    chk("R7 idle level", p1_out, 1'b1);
    fifo_count = 7'd100; step(2);
    chk("R7 asserted low", p1_out, 1'b0);
    chk("R7 driven", p1_oe, 1'b1);
    fifo_count = 0; p1_pol = 0; step(2);

    // R8: sequence window
    cur_req = "R8";
    p1_alt = 5'd2; p1_drv = 1; step(2);
    chk("R8 closed", p1_oe, 1'b0);
    seq_start = 1; step(1); seq_start = 0;
    chk("R8 latency one edge", p1_oe, 1'b0);
    step(1);
    chk("R8 open", p1_oe, 1'b1);
    chk("R8 open level", p1_out, 1'b1);
    step(3);
    seq_end = 1; step(1); seq_end = 0; step(1);
    chk("R8 closed by end", p1_oe, 1'b0);
    seq_start = 1; seq_end = 1; step(1); seq_start = 0; seq_end = 0; step(1);
    chk("R8 start wins", p1_oe, 1'b1);

    // R9: unsupported codes
    cur_req = "R9";
    fifo_count = 7'd100; p1_drv = 0;
    p1_alt = 5'd0; step(2);
    chk("R9 code 0", p1_oe, 1'b0);
    p1_alt = 5'd3; step(2);
    chk("R9 code 3", p1_oe, 1'b0);
    p1_alt = 5'd31; step(2);
    chk("R9 code 31", p1_oe, 1'b0);
    fifo_count = 0; step(3);

    finish_run();
  end
endmodule